// File: doc/BRIEF.md
# Indexed Memory-Window Routing Register File

This block sits on a narrow I/O bus and exposes a 256-byte register file through two ports: an index port and a data port. A write to the index port selects an entry; a write to the data port stores a byte into the selected entry, and a read of the data port returns it. The index stays put between accesses, so software can read or write one entry repeatedly without reloading it.

Two of the entries control where low memory is served from. Bit 0 of entry 0 and bit 0 of entry 1 each choose, for one fixed window of the 20-bit physical space, whether on-board RAM answers or the access goes out to the external bus. These choices are held in registered routing flags, which are refreshed after every data-port write. A combinational classifier takes any 20-bit address and reports whether that address is currently served internally, so a memory decoder elsewhere can steer each cycle without knowing the window bounds.

Top module: `memwin_regfile`

## Requirements
- R1: A write cycle (`io_wr`=1) with `io_port`=0x00E0 loads `io_wdata` into the 8-bit index; later data-port accesses use that entry.
- R2: A write cycle with `io_port`=0x00E1 stores `io_wdata` into the entry selected by the index; no other entry changes.
- R3: While `io_rd`=1 and `io_port`=0x00E1, `io_rdata` shows the selected entry in the same cycle; in every other cycle `io_rdata` is 0xFF.
- R4: `win_internal[0]` routes addresses 0x00000–0x7FFFF and follows bit 0 of entry 0; `win_internal[1]` routes 0x80000–0x9FFFF and follows bit 0 of entry 1; 1 means on-board RAM, 0 means external bus. The other bits of those entries have no effect on routing.
- R5: The routing flags are refreshed only on the clock edge that follows the edge that completed a data-port write, taking the entry values current at that edge; in all other cycles they hold.
- R6: Synchronous active-high `rst` clears the index, every entry and both routing flags, so both windows start external and a data-port read returns 0x00.
- R7: `probe_internal` is 0 for any `probe_addr` at or above 0xA0000, whatever the register contents.
- R8: For `probe_addr` below 0xA0000, `probe_internal` equals the routing flag of the window containing the address, combinationally.
- R9: Writes to any port other than 0x00E0 and 0x00E1 change neither the index, the entries nor the routing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | I/O write strobe, one access per cycle |
| io_rd | input | 1 | I/O read strobe |
| io_port | input | 16 | I/O port address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, 0xFF when the data port is not being read |
| win_internal | output | 2 | Registered routing flag per low-memory window |
| probe_addr | input | 20 | Physical address to classify |
| probe_internal | output | 1 | 1 when `probe_addr` is served by on-board RAM |

## Verification
The assertions assume `io_wr` and `io_rd` are never high together and that reset is held for at least two clock edges, so every `$past` term after reset refers to defined state. The bench drives one access per cycle with the strobes mutually exclusive, holds reset for three cycles, and compares the read data, routing flags and classifier output against a behavioural model every cycle, with probe addresses sweeping the window boundaries 0x7FFFF, 0x80000, 0x9FFFF and 0xA0000.

// File: rtl/memwin_pkg.sv
package memwin_pkg;

    localparam int IO_AW    = 16;
    localparam int DW       = 8;
    localparam int IW       = 8;
    localparam int PAW      = 20;
    localparam int NUM_WIN  = 2;

    localparam logic [IO_AW-1:0] IDX_PORT = 16'h00E0;
    localparam logic [IO_AW-1:0] DAT_PORT = 16'h00E1;

    // Upper bound (exclusive) of each window, window 0 first.
    localparam logic [NUM_WIN*PAW-1:0] WIN_ENDS = {20'hA0000, 20'h80000};

    localparam logic [DW-1:0] FLOAT_BYTE = '1;

    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_IDX_WR = 2'd1,
        ACC_DAT_WR = 2'd2,
        ACC_DAT_RD = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic idx_wr;
        logic dat_wr;
        logic dat_rd;
    } acc_t;

    function automatic acc_t acc_from_kind(acc_kind_e k);
        acc_t a;
        a.idx_wr = (k == ACC_IDX_WR);
        a.dat_wr = (k == ACC_DAT_WR);
        a.dat_rd = (k == ACC_DAT_RD);
        return a;
    endfunction

    function automatic logic [PAW-1:0] win_lo(int g);
        logic [PAW-1:0] lo;
        lo = '0;
        if (g > 0) lo = WIN_ENDS[(g-1)*PAW +: PAW];
        return lo;
    endfunction

    function automatic logic [PAW-1:0] win_hi(int g);
        return WIN_ENDS[g*PAW +: PAW];
    endfunction

endpackage

// File: rtl/memwin_port_decode.sv
module memwin_port_decode
    import memwin_pkg::*;
#(
    parameter int                 AW       = IO_AW,
    parameter logic [AW-1:0]      P_INDEX  = IDX_PORT,
    parameter logic [AW-1:0]      P_DATA   = DAT_PORT
) (
    input  logic          wr,
    input  logic          rd,
    input  logic [AW-1:0] port,
    output acc_t          acc
);
    acc_kind_e kind;

    always_comb begin
        kind = ACC_NONE;
        if (wr && port == P_INDEX)      kind = ACC_IDX_WR;
        else if (wr && port == P_DATA)  kind = ACC_DAT_WR;
        else if (rd && port == P_DATA)  kind = ACC_DAT_RD;
    end

    assign acc = acc_from_kind(kind);
endmodule

// File: rtl/memwin_store.sv
module memwin_store
    import memwin_pkg::*;
#(
    parameter int IDX_W = IW,
    parameter int DAT_W = DW,
    parameter int NWIN  = NUM_WIN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idx_wr,
    input  logic             dat_wr,
    input  logic [DAT_W-1:0] wdata,
    output logic [DAT_W-1:0] sel_entry,
    output logic [NWIN-1:0]  win_bits
);
    localparam int DEPTH = 1 << IDX_W;

    logic [IDX_W-1:0] idx_q;
    logic [DAT_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (idx_wr) idx_q <= wdata[IDX_W-1:0];
            if (dat_wr) mem_q[idx_q] <= wdata;
        end
    end

    assign sel_entry = mem_q[idx_q];

    for (genvar g = 0; g < NWIN; g++) begin : g_winbit
        assign win_bits[g] = mem_q[g][0];
    end

    // R1: the index register captures the written byte
    p_index_load_r1: assert property (@(posedge clk) disable iff (rst)
        idx_wr |=> idx_q == $past(wdata[IDX_W-1:0]));

    // R2: the selected entry holds the written byte after a data write
    p_entry_store_r2: assert property (@(posedge clk) disable iff (rst)
        dat_wr |=> sel_entry == $past(wdata) || $past(idx_wr));

endmodule

// File: rtl/memwin_route.sv
module memwin_route
    import memwin_pkg::*;
#(
    parameter int NWIN = NUM_WIN
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            dat_wr,
    input  logic [NWIN-1:0] win_bits,
    output logic [NWIN-1:0] route_q
);
    logic recalc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            recalc_q <= 1'b0;
            route_q  <= '0;
        end else begin
            recalc_q <= dat_wr;
            if (recalc_q) route_q <= win_bits;
        end
    end

    // R5: routing holds unless a data write completed on the previous edge
    p_route_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(dat_wr, 2) |-> $stable(route_q) || $past(rst, 2) || $past(rst));

    // R4: after a refresh the flags equal the entry bits seen at that edge
    p_route_follow_r4: assert property (@(posedge clk) disable iff (rst)
        $past(dat_wr) && !$past(rst) |=> route_q == $past(win_bits));

endmodule

// File: rtl/memwin_classify.sv
module memwin_classify
    import memwin_pkg::*;
#(
    parameter int ADDR_W = PAW,
    parameter int NWIN   = NUM_WIN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NWIN-1:0]   route,
    output logic              internal
);
    logic [NWIN-1:0] in_win;

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        localparam logic [ADDR_W-1:0] LO = win_lo(g);
        localparam logic [ADDR_W-1:0] HI = win_hi(g);
        if (g == 0) begin : g_first
            assign in_win[g] = (addr < HI);
        end else begin : g_rest
            assign in_win[g] = (addr >= LO) && (addr < HI);
        end
    end

    assign internal = |(in_win & route);

    localparam logic [ADDR_W-1:0] TOP_END = win_hi(NWIN - 1);

    // R7: nothing above the last window is ever internal
    p_upper_external_r7: assert property (@(posedge clk) disable iff (rst)
        (addr >= TOP_END) |-> !internal);

    // R8: at most one window claims an address
    p_single_window_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(in_win));

endmodule

// File: rtl/memwin_regfile.sv
module memwin_regfile
    import memwin_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             io_wr,
    input  logic             io_rd,
    input  logic [IO_AW-1:0] io_port,
    input  logic [DW-1:0]    io_wdata,
    output logic [DW-1:0]    io_rdata,
    output logic [NUM_WIN-1:0] win_internal,
    input  logic [PAW-1:0]   probe_addr,
    output logic             probe_internal
);
    acc_t            acc;
    logic [DW-1:0]   sel_entry;
    logic [NUM_WIN-1:0] win_bits;

    memwin_port_decode #(
        .AW      (IO_AW),
        .P_INDEX (IDX_PORT),
        .P_DATA  (DAT_PORT)
    ) u_decode (
        .wr   (io_wr),
        .rd   (io_rd),
        .port (io_port),
        .acc  (acc)
    );

    memwin_store #(
        .IDX_W (IW),
        .DAT_W (DW),
        .NWIN  (NUM_WIN)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .idx_wr    (acc.idx_wr),
        .dat_wr    (acc.dat_wr),
        .wdata     (io_wdata),
        .sel_entry (sel_entry),
        .win_bits  (win_bits)
    );

    memwin_route #(
        .NWIN (NUM_WIN)
    ) u_route (
        .clk      (clk),
        .rst      (rst),
        .dat_wr   (acc.dat_wr),
        .win_bits (win_bits),
        .route_q  (win_internal)
    );

    memwin_classify #(
        .ADDR_W (PAW),
        .NWIN   (NUM_WIN)
    ) u_classify (
        .clk      (clk),
        .rst      (rst),
        .addr     (probe_addr),
        .route    (win_internal),
        .internal (probe_internal)
    );

    assign io_rdata = acc.dat_rd ? sel_entry : FLOAT_BYTE;

    // R3: a data-port read never floats
    p_read_drives_r3: assert property (@(posedge clk) disable iff (rst)
        (io_rd && !io_wr && io_port == DAT_PORT) |-> io_rdata == sel_entry);

    // R9: a write to an unrelated port leaves the selected entry alone
    p_foreign_write_r9: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_port != IDX_PORT && io_port != DAT_PORT) |=> $stable(sel_entry));

endmodule

// File: tb/memwin_regfile_bench.sv
`timescale 1ns/1ps
module memwin_regfile_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [15:0] io_port = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [1:0]  win_internal;
    logic [19:0] probe_addr = '0;
    logic        probe_internal;

    always #2.5 clk = ~clk;

    memwin_regfile u_memwin_regfile (
        .clk            (clk),
        .rst            (rst),
        .io_wr          (io_wr),
        .io_rd          (io_rd),
        .io_port        (io_port),
        .io_wdata       (io_wdata),
        .io_rdata       (io_rdata),
        .win_internal   (win_internal),
        .probe_addr     (probe_addr),
        .probe_internal (probe_internal)
    );

    // behavioural model
    int    m_mem [256];
    int    m_idx;
    int    m_route0, m_route1;
    bit    m_pend;
    int    n_chk, n_fail, pcnt;
    string tag;

    task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", t, act, exp);
        end
    endtask

    function automatic logic [19:0] next_probe();
        logic [19:0] v;
        case (pcnt % 8)
            0: v = 20'h7FFFF;
            1: v = 20'h80000;
            2: v = 20'h9FFFF;
            3: v = 20'hA0000;
            4: v = 20'h00000;
            5: v = 20'hFFFFF;
            default: v = 20'($urandom_range(0, 20'hFFFFF));
        endcase
        pcnt++;
        return v;
    endfunction

    task automatic step(bit r, bit wr, bit rd, logic [15:0] port, logic [7:0] d);
        int exp_rd, exp_pi;
        @(negedge clk);
        rst = r; io_wr = wr; io_rd = rd; io_port = port; io_wdata = d;
        probe_addr = next_probe();
        #1;
        if (!r) begin
            exp_rd = (rd && port == 16'h00E1) ? m_mem[m_idx] : 8'hFF;
            chk(tag, io_rdata, exp_rd);
            chk(tag == "R4" ? "R4" : "R5", win_internal, 32'(m_route1 * 2 + m_route0));
            if (probe_addr < 20'h80000)      exp_pi = m_route0;
            else if (probe_addr < 20'hA0000) exp_pi = m_route1;
            else                             exp_pi = 0;
            chk(probe_addr >= 20'hA0000 ? "R7" : "R8", probe_internal, exp_pi);
        end
        @(posedge clk);
        if (r) begin
            foreach (m_mem[i]) m_mem[i] = 0;
            m_idx = 0; m_route0 = 0; m_route1 = 0; m_pend = 0;
        end else begin
            if (m_pend) begin
                m_route0 = m_mem[0] & 1;
                m_route1 = m_mem[1] & 1;
            end
            m_pend = wr && port == 16'h00E1;
            if (wr && port == 16'h00E0) m_idx = d;
            else if (wr && port == 16'h00E1) m_mem[m_idx] = d;
        end
    endtask

    task automatic put(logic [7:0] idx, logic [7:0] d);
        step(0, 1, 0, 16'h00E0, idx);
        step(0, 1, 0, 16'h00E1, d);
    endtask

    task automatic peek(logic [7:0] idx);
        step(0, 1, 0, 16'h00E0, idx);
        step(0, 0, 1, 16'h00E1, 8'h00);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        tag = "R6";
        repeat (3) step(1, 0, 0, 16'h0000, 8'h00);
        // R6: reset state - index 0, entries 0, both windows external
        step(0, 0, 1, 16'h00E1, 8'h00);
        chk("R6", io_rdata, 8'h00);
        peek(8'hFF);
        peek(8'h01);

        tag = "R1";
        step(0, 1, 0, 16'h00E0, 8'h37);
        step(0, 0, 1, 16'h00E1, 8'h00);
        step(0, 1, 0, 16'h00E1, 8'hA5);
        step(0, 0, 1, 16'h00E1, 8'h00);
        step(0, 0, 1, 16'h00E1, 8'h00);
        peek(8'h36);
        peek(8'h37);

        tag = "R2";
        for (int i = 2; i < 48; i++) put(8'(i), 8'(i * 7 + 3));
        for (int i = 0; i < 50; i++) peek(8'(i));
        put(8'hFF, 8'h5A);
        peek(8'hFE);
        peek(8'hFF);

        tag = "R3";
        step(0, 0, 0, 16'h00E1, 8'h00);
        step(0, 0, 1, 16'h00E0, 8'h00);
        step(0, 0, 1, 16'h01E1, 8'h00);
        step(0, 0, 1, 16'h00E1, 8'h00);

        tag = "R4";
        put(8'h00, 8'h01);
        repeat (3) step(0, 0, 0, 16'h0000, 8'h00);
        put(8'h01, 8'hFF);
        repeat (3) step(0, 0, 0, 16'h0000, 8'h00);
        put(8'h00, 8'hFE);
        repeat (3) step(0, 0, 0, 16'h0000, 8'h00);
        put(8'h01, 8'h02);
        repeat (3) step(0, 0, 0, 16'h0000, 8'h00);

        tag = "R5";
        put(8'h01, 8'h01);
        step(0, 1, 0, 16'h00E1, 8'h00);
        step(0, 1, 0, 16'h00E1, 8'h01);
        step(0, 1, 0, 16'h00E1, 8'h00);
        repeat (3) step(0, 0, 0, 16'h0000, 8'h00);
        put(8'h07, 8'h01);
        repeat (2) step(0, 0, 0, 16'h0000, 8'h00);

        tag = "R9";
        put(8'h00, 8'h01);
        step(0, 1, 0, 16'h00E2, 8'h00);
        step(0, 1, 0, 16'h01E1, 8'h00);
        step(0, 1, 0, 16'h00DF, 8'h05);
        step(0, 1, 0, 16'h10E0, 8'h05);
        step(0, 0, 1, 16'h00E1, 8'h00);
        repeat (3) step(0, 0, 0, 16'h0000, 8'h00);
        peek(8'h00);

        tag = "R8";
        for (int i = 0; i < 600; i++) begin
            int sel;
            logic [15:0] p;
            sel = $urandom_range(0, 5);
            case (sel)
                0, 1: p = 16'h00E0;
                2, 3: p = 16'h00E1;
                4:    p = 16'h00E2;
                default: p = 16'h01E1;
            endcase
            if (p == 16'h00E0)
                step(0, 1, 0, p, 8'($urandom_range(0, 3)));
            else if ($urandom_range(0, 1) == 1)
                step(0, 1, 0, p, 8'($urandom));
            else
                step(0, 0, 1, p, 8'h00);
        end

        summary();
        $finish;
    end
endmodule